// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for a 32-bit memory-mapped register bus. Software programs a prescaler divisor and a reload count, and starts the timer. From then on it must refresh the timer before the count runs out. If the count runs out, the block raises a one-cycle reset request toward the system reset logic and then starts the next period on its own.

Every bus write has to carry a fixed key, 0x1234, in bits 31:16. A write without that key changes nothing. The divisor and the reload count are written first as pending values and do not act yet. The refresh register holds three 2-bit codes. When software flips one of these codes between 1 and 2, the matching action runs: the pending divisor takes effect, the counter reloads from the pending count, or the interrupt value is refreshed. Writing the refresh register with its current contents XORed with 0x3F runs all three actions at once.

The counter advances on `tickEn`, which is a one-cycle enable from the slow timer clock domain. The prescaler divides that enable by the programmed divisor, and each divided tick moves the counter down by one.

Top module: `keyed_wdt`

## Requirements
- R1: A write takes effect only when wrData[31:16] equals 0x1234. Any other write leaves all four registers, the counter and both pulse outputs unchanged.
- R2: Reads put the stored value in the low bits and zeros everywhere else. Configuration (offset 0x04) returns 16 bits. Load (offset 0x08) returns 16 bits. Refresh (offset 0x18) returns bits 5:0. Start (offset 0x1C) returns bit 0 only.
- R3: After reset, the configuration reads 0x0F00 (divisor 16), the load reads 0xFFFF, the refresh reads 0x15 and the start register reads 0. Both outputs are low.
- R4: A refresh group acts only when its stored code and its newly written code are 1 and 2, or 2 and 1. Any other pair of codes, 3 for example, triggers nothing. The write still stores the new code.
- R5: A write to the load register only sets the pending count. When group bits 3:2 toggle, the counter and the active reload value take the pending count in that same cycle, and the prescaler is cleared.
- R6: The divisor is field bits 15:8 plus one, giving 1 to 256. A configuration write acts only when group bits 5:4 toggle, which also clears the prescaler.
- R7: While start bit 0 is 1, every divided tick decrements the counter. A divided tick that finds the counter at 0 produces a one-cycle resetReq and reloads the active value. After a reload with count L and divisor D, the first pulse therefore comes D*(L+1) ticks later.
- R8: While start bit 0 is 0, the counter and the prescaler hold their values. Setting the bit again resumes the countdown from where it stopped.
- R9: Each toggle of group bits 1:0 produces a one-cycle irqPulse in the cycle after the write.
- R10: Only cycles with tickEn high advance the prescaler. With tickEn low, the countdown does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle timer tick enable |
| wrEn | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wrData | input | 32 | Write word: key in 31:16, data in 15:0 |
| rdData | output | 32 | Combinational read of the addressed register |
| resetReq | output | 1 | One-cycle reset request on expiry |
| irqPulse | output | 1 | One-cycle pulse on an interrupt-value refresh |

## Verification
The countdown is run with several setups: divisor 1 with counts 5 and 2, divisor 3 with count 3, and a stretch where tickEn is held low. The exact pulse cycles separate a correct count from an off-by-one in either the divisor or the reload count. Refresh writes use true toggles, the non-toggling code 3, and a 3-to-2 change. Together with reloads whose pending value differs from the active one, these show whether a reload really came from a toggle or the counter kept running from the older value. Key-less writes to every register, a start/stop/resume sequence, and a toggle of only group bits 1:0 separate the write gating, freezing and interrupt-refresh behaviour from the countdown.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int unsigned OFS_CFG  = 32'h04;
  localparam int unsigned OFS_LOAD = 32'h08;
  localparam int unsigned OFS_KICK = 32'h18;
  localparam int unsigned OFS_RUN  = 32'h1C;

  localparam logic [15:0] WR_KEY = 16'h1234;
  localparam int GROUPS = 3;
  localparam int KICK_W = 2 * GROUPS;

  typedef struct packed {
    logic commitCfg;
    logic reloadCnt;
    logic irqRefresh;
    logic runEn;
  } wdStrobe_t;
endpackage

// File: rtl/keyed_wdt_ctrl.sv
module keyed_wdt_ctrl
  import keyed_wdt_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int CNT_W   = 16,
  parameter int DIV_W   = 8,
  parameter int DEF_DIV = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [DIV_W-1:0]  cfgDivM1,
  output logic [CNT_W-1:0]  loadPend,
  output wdStrobe_t         strobes
);
  localparam logic [15:0]       CFG_RST  = 16'((DEF_DIV - 1) << 8);
  localparam logic [KICK_W-1:0] KICK_RST = KICK_W'(6'h15);

  logic [15:0]       cfgQ;
  logic [CNT_W-1:0]  loadQ;
  logic [KICK_W-1:0] kickQ;
  logic              runQ;
  logic              keyedWr, kickWr;
  logic [GROUPS-1:0] act;

  assign keyedWr = wrEn && (wrData[31:16] == WR_KEY);
  assign kickWr  = keyedWr && (addr == ADDR_W'(OFS_KICK));

  // Per-group toggle decode: acts only on a 1 <-> 2 change of the 2-bit code
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [1:0] oldC, newC;
    assign oldC = kickQ[2*g +: 2];
    assign newC = wrData[2*g +: 2];
    assign act[g] = kickWr && (((oldC == 2'd1) && (newC == 2'd2)) ||
                               ((oldC == 2'd2) && (newC == 2'd1)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= CFG_RST;
      loadQ <= '1;
      kickQ <= KICK_RST;
      runQ  <= 1'b0;
    end else if (keyedWr) begin
      if (addr == ADDR_W'(OFS_CFG))  cfgQ  <= wrData[15:0];
      if (addr == ADDR_W'(OFS_LOAD)) loadQ <= wrData[CNT_W-1:0];
      if (addr == ADDR_W'(OFS_KICK)) kickQ <= wrData[KICK_W-1:0];
      if (addr == ADDR_W'(OFS_RUN))  runQ  <= wrData[0];
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(OFS_CFG))  rdData[15:0]       = cfgQ;
    if (addr == ADDR_W'(OFS_LOAD)) rdData[CNT_W-1:0]  = loadQ;
    if (addr == ADDR_W'(OFS_KICK)) rdData[KICK_W-1:0] = kickQ;
    if (addr == ADDR_W'(OFS_RUN))  rdData[0]          = runQ;
  end

  assign cfgDivM1          = cfgQ[8 +: DIV_W];
  assign loadPend          = loadQ;
  assign strobes.commitCfg  = act[2];
  assign strobes.reloadCnt  = act[1];
  assign strobes.irqRefresh = act[0];
  assign strobes.runEn      = runQ;

  // R1: a key-less write leaves every register as it was
  p_key_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrData[31:16] != WR_KEY)) |=>
      ($stable(cfgQ) && $stable(loadQ) && $stable(kickQ) && $stable(runQ)));

  // R4: a reload strobe is always accompanied by a real change of that group's code
  p_toggle_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reloadCnt |=> (kickQ[3:2] != $past(kickQ[3:2])));

  // R6: a commit strobe only ever follows a code of 1 or 2 in group 5:4
  p_commit_code_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitCfg |=> ((kickQ[5:4] == 2'd1) || (kickQ[5:4] == 2'd2)));
endmodule

// File: rtl/keyed_wdt_dp.sv
module keyed_wdt_dp
  import keyed_wdt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DIV_W   = 8,
  parameter int DEF_DIV = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic [DIV_W-1:0] cfgDivM1,
  input  logic [CNT_W-1:0] loadPend,
  input  wdStrobe_t        strobes,
  output logic             resetReq,
  output logic             irqPulse
);
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(DEF_DIV - 1);

  logic [DIV_W-1:0] divM1Q, preQ;
  logic [CNT_W-1:0] loadActQ, cntQ;
  logic             divTick, runEn, restart;

  assign runEn   = strobes.runEn;
  assign restart = strobes.commitCfg || strobes.reloadCnt;
  assign divTick = tickEn && (preQ == divM1Q);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divM1Q   <= DIV_RST;
      loadActQ <= '1;
      cntQ     <= '1;
      preQ     <= '0;
      resetReq <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      resetReq <= 1'b0;
      irqPulse <= strobes.irqRefresh;
      if (strobes.commitCfg) divM1Q   <= cfgDivM1;
      if (strobes.reloadCnt) loadActQ <= loadPend;

      if (restart)                preQ <= '0;
      else if (runEn && tickEn)   preQ <= divTick ? '0 : preQ + 1'b1;

      if (strobes.reloadCnt) begin
        cntQ <= loadPend;
      end else if (runEn && divTick) begin
        if (cntQ == '0) begin
          cntQ     <= loadActQ;
          resetReq <= 1'b1;
        end else begin
          cntQ <= cntQ - 1'b1;
        end
      end
    end
  end

  // R7: a reset request only follows a running tick that found the count at zero
  p_pulse_from_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> ($past(cntQ) == '0 && $past(runEn) && $past(tickEn)));

  // R7: an ordinary divided tick removes exactly one count
  p_single_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && divTick && !strobes.reloadCnt && cntQ != '0) |=> (cntQ == $past(cntQ) - 1'b1));

  // R5: a reload lands the pending count in the counter
  p_reload_value_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reloadCnt |=> (cntQ == $past(loadPend)));

  // R8: a stopped watchdog holds its count and prescaler
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !restart) |=> ($stable(cntQ) && $stable(preQ)));

  // R9: the interrupt-value pulse answers a group 1:0 toggle
  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(strobes.irqRefresh));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int CNT_W   = 16,
  parameter int DIV_W   = 8,
  parameter int DEF_DIV = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              resetReq,
  output logic              irqPulse
);
  wdStrobe_t        strobes;
  logic [DIV_W-1:0] cfgDivM1;
  logic [CNT_W-1:0] loadPend;

  keyed_wdt_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .cfgDivM1(cfgDivM1), .loadPend(loadPend), .strobes(strobes)
  );

  keyed_wdt_dp #(.CNT_W(CNT_W), .DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cfgDivM1(cfgDivM1), .loadPend(loadPend),
    .strobes(strobes), .resetReq(resetReq), .irqPulse(irqPulse)
  );
endmodule

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  localparam logic [4:0] A_CFG = 5'h04, A_LOAD = 5'h08, A_KICK = 5'h18, A_RUN = 5'h1C;
  localparam logic [31:0] KEY = 32'h1234_0000;

  logic clk = 1'b0, rstN, tickEn, wrEn;
  logic [4:0]  addr;
  logic [31:0] wrData, rdData;
  logic resetReq, irqPulse;

  int cyc = 0, nChecks = 0, nFails = 0;
  int rstQ[$];
  int irqQ[$];
  string tag = "R3";
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  keyed_wdt u_keyed_wdt (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .resetReq(resetReq), .irqPulse(irqPulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver: one bus write; queues the expected irq pulse before the edge it lands on
  task automatic wr(input logic [4:0] a, input logic [31:0] d, input bit expIrq, output int edgeN);
    edgeN = cyc + 1;
    if (expIrq) irqQ.push_back(edgeN);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic wrq(input logic [4:0] a, input logic [31:0] d);
    int unused;
    wr(a, d, 1'b0, unused);
  endtask

  task automatic rdChk(input logic [4:0] a, input int exp, input string req);
    addr = a;
    #1;
    chk(rdData == 32'(exp), req, int'(rdData), exp);
  endtask

  task automatic waitUntil(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: compares each pulse against the front of its queue
  always @(negedge clk) begin
    if (rstN === 1'b1 && !done) begin
      if (rstQ.size() > 0 && cyc > rstQ[0]) begin
        chk(1'b0, tag, 0, rstQ[0]); void'(rstQ.pop_front());
      end
      if (resetReq) begin
        if (rstQ.size() == 0) chk(1'b0, tag, cyc, -1);
        else begin chk(cyc == rstQ[0], tag, cyc, rstQ[0]); void'(rstQ.pop_front()); end
      end
      if (irqQ.size() > 0 && cyc > irqQ[0]) begin
        chk(1'b0, "R9", 0, irqQ[0]); void'(irqQ.pop_front());
      end
      if (irqPulse) begin
        if (irqQ.size() == 0) chk(1'b0, "R9", cyc, -1);
        else begin chk(cyc == irqQ[0], "R9", cyc, irqQ[0]); void'(irqQ.pop_front()); end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int e, r, s, t, x;
    rstN = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0; tickEn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R3 reset state
    rdChk(A_CFG, 32'h0F00, "R3"); rdChk(A_LOAD, 32'hFFFF, "R3");
    rdChk(A_KICK, 32'h15, "R3");  rdChk(A_RUN, 0, "R3");
    chk(resetReq == 1'b0 && irqPulse == 1'b0, "R3", int'(resetReq), 0);

    // R2 read formatting
    wrq(A_CFG, KEY | 32'h0000); wrq(A_LOAD, KEY | 32'h0005); wrq(A_RUN, KEY | 32'hFFFF);
    rdChk(A_CFG, 0, "R2"); rdChk(A_LOAD, 5, "R2"); rdChk(A_RUN, 1, "R2");

    // R7 divisor 1, count 5: period 6
    tag = "R7";
    wr(A_KICK, KEY | 32'h2A, 1'b1, e);
    rstQ.push_back(e + 6); rstQ.push_back(e + 12); rstQ.push_back(e + 18);
    waitUntil(e + 18); wrq(A_RUN, KEY);
    rdChk(A_KICK, 32'h2A, "R2");

    // R1 key-less writes change nothing
    tag = "R1";
    wrq(A_LOAD, 32'hABCD_0002); rdChk(A_LOAD, 5, "R1");
    wrq(A_KICK, 32'hAAAA_0015); rdChk(A_KICK, 32'h2A, "R1");
    wrq(A_RUN, 32'h0000_0001);  rdChk(A_RUN, 0, "R1");
    wrq(A_CFG, 32'h1235_0700);  rdChk(A_CFG, 0, "R1");
    repeat (20) @(negedge clk);

    // R4 R5: non-toggling code does nothing; pending load stays inactive
    tag = "R4 R5";
    wrq(A_LOAD, KEY | 32'h2); wrq(A_KICK, KEY | 32'h3F);
    rdChk(A_KICK, 32'h3F, "R4");
    wr(A_RUN, KEY | 32'h1, 1'b0, r);
    rstQ.push_back(r + 5); rstQ.push_back(r + 11);
    waitUntil(r + 11); wrq(A_RUN, KEY);
    wrq(A_KICK, KEY | 32'h2A);
    repeat (5) @(negedge clk);

    // R8 stop and resume; R5 reload to pending count 2
    tag = "R8";
    wr(A_KICK, KEY | 32'h15, 1'b1, e);
    wr(A_RUN, KEY | 32'h1, 1'b0, r);
    wr(A_RUN, KEY, 1'b0, s);
    repeat (7) @(negedge clk);
    wr(A_RUN, KEY | 32'h1, 1'b0, t);
    rstQ.push_back(t + 2); rstQ.push_back(t + 5);
    waitUntil(t + 5); wrq(A_RUN, KEY);

    // R6 divisor 3, count 3: 12 ticks
    tag = "R6";
    wrq(A_CFG, KEY | 32'h0200); wrq(A_LOAD, KEY | 32'h3);
    wr(A_KICK, KEY | 32'h2A, 1'b1, e);
    wr(A_RUN, KEY | 32'h1, 1'b0, r);
    rstQ.push_back(r + 12);
    waitUntil(r + 12);

    // R10 tickEn low freezes progress
    tag = "R10";
    tickEn = 1'b0;
    repeat (30) @(negedge clk);
    x = cyc; tickEn = 1'b1;
    rstQ.push_back(x + 12);
    waitUntil(x + 12); wrq(A_RUN, KEY);

    // R9 interrupt-value group alone; 1 -> 3 is not a toggle
    tag = "R9";
    wr(A_KICK, KEY | 32'h29, 1'b1, e);
    rdChk(A_KICK, 32'h29, "R9");
    wr(A_KICK, KEY | 32'h2B, 1'b0, e);
    repeat (10) @(negedge clk);

    chk(rstQ.size() == 0, "R7", rstQ.size(), 0);
    chk(irqQ.size() == 0, "R9", irqQ.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule